// File: doc/BRIEF.md
# Five-Pin Bidirectional GPIO Port

This block is a general-purpose I/O port of five pins. Software reaches it through a small synchronous register bus that has three registers. The pin-level register reads back what the pads actually carry. The output-latch register holds the values that the port drives. The direction register sets, per pin, whether the output driver is enabled. The block does not own a tri-state pad. It presents, for each pin, an output value, an output enable and a sampled input, so the pad can be modelled outside.

Pins 0 to 3 can be handed to analog use through an analog-select mask. A comparator-enable input claims pins 0 and 3 as comparator inputs and lets a comparator result drive pin 4 in place of its latch bit. A pin claimed this way reads as zero on the pin-level register. Its direction bit still controls its output enable.

Pin inputs pass through a synchronizer before software can see them. Read data is registered, so it is valid one cycle after the address is presented.

Top module: `gpio5_port`

## Requirements
- R1: After reset the direction register reads 0x1F, the latch reads 0x00 and every output enable is low.
- R2: A direction bit of 0 raises that pin's output enable and drives its latch bit on pinOut. A direction bit of 1 lowers the output enable.
- R3: The pin-level register (address 0) returns the pin inputs after a two-flop synchronizer. A pin change becomes visible in the read data on the third rising edge after the change, and not on the second.
- R4: A write to address 0 or address 1 loads the output latch. Address 1 reads back the latch contents, whatever the pins carry.
- R5: On address 0, a pin among bits 0–3 whose analogSel bit is 1 reads 0. analogSel bit 4 has no effect, and pin 4 always reads its synchronized level.
- R6: A pin in analog mode keeps its output enable set by its direction bit.
- R7: While cmpEn is 1, bits 0 and 3 of address 0 read 0.
- R8: While cmpEn is 1, pinOut bit 4 follows cmpOut instead of latch bit 4. While cmpEn is 0, it follows the latch.
- R9: Read-data bits 7:5 are always 0. Address 3 reads 0x00, and a write to address 3 changes neither the latch nor the direction.
- R10: Open-drain use works as follows. With latch bit 0, clearing the direction bit drives pinOut 0 with the enable high, and setting the direction bit releases the line with the enable low.
- R11: Read data appears one cycle after the address. A read in the same cycle as a write to the same register returns the value from before the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register select: 0 pin level, 1 latch, 2 direction |
| busWrEn | input | 1 | Write strobe |
| busWrData | input | 8 | Write data |
| busRdData | output | 8 | Registered read data |
| analogSel | input | 5 | Analog claim mask; only bits 0–3 are honoured |
| cmpEn | input | 1 | Comparator claims pins 0, 3 and output on pin 4 |
| cmpOut | input | 1 | Comparator result driven on pin 4 when enabled |
| pinIn | input | 5 | Pad input levels |
| pinOut | output | 5 | Pad output values |
| pinOe | output | 5 | Pad output enables, 1 = drive |

## Verification
Two functions can land on the same edge: a register write, and the registered read of the same address. The bench provokes this by asserting a latch write while the address selects the latch, and also while it selects the direction register. It then samples the read data after that edge and expects the old contents, and on the next read it expects the new contents. A second overlap occurs when a pin changes while a read is in flight. The bench reads on each of the three edges after the change and expects the old level twice before the new level appears.

// File: rtl/gpio5_pkg.sv
package gpio5_pkg;
  localparam int PORT_W = 5;
  localparam int BUS_W  = 8;
  localparam int ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    SEL_PIN  = 2'd0,
    SEL_LAT  = 2'd1,
    SEL_DIR  = 2'd2,
    SEL_NONE = 2'd3
  } regSel_e;

  typedef struct packed {
    logic    wrLat;
    logic    wrDir;
    regSel_e rdSel;
  } portStrobe_t;
endpackage

// File: rtl/gpio5_ctrl.sv
module gpio5_ctrl
  import gpio5_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  output portStrobe_t       strobe
);
  always_comb begin
    strobe.wrLat = 1'b0;
    strobe.wrDir = 1'b0;
    strobe.rdSel = SEL_NONE;
    unique case (busAddr)
      2'd0: begin strobe.rdSel = SEL_PIN; strobe.wrLat = busWrEn; end
      2'd1: begin strobe.rdSel = SEL_LAT; strobe.wrLat = busWrEn; end
      2'd2: begin strobe.rdSel = SEL_DIR; strobe.wrDir = busWrEn; end
      default: strobe.rdSel = SEL_NONE;
    endcase
  end
endmodule

// File: rtl/gpio5_datapath.sv
module gpio5_datapath
  import gpio5_pkg::*;
#(
  parameter int                PW          = PORT_W,
  parameter int                BW          = BUS_W,
  parameter int                SYNC_STAGES = 2,
  parameter logic [PW-1:0]     ANALOG_CAP  = 5'h0F,
  parameter logic [PW-1:0]     CMP_IN_MASK = 5'h09,
  parameter int                CMP_OUT_IDX = 4
) (
  input  logic          clk,
  input  logic          rstN,
  input  portStrobe_t   strobe,
  input  logic [BW-1:0] wrData,
  output logic [BW-1:0] rdData,
  input  logic [PW-1:0] analogSel,
  input  logic          cmpEn,
  input  logic          cmpOut,
  input  logic [PW-1:0] pinIn,
  output logic [PW-1:0] pinOut,
  output logic [PW-1:0] pinOe
);
  localparam int PAD_W = BW - PW;

  logic [PW-1:0] latQ, dirQ;
  logic [PW-1:0] syncQ [SYNC_STAGES];
  logic [PW-1:0] claimMask, pinView, rdNext;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      latQ <= '0;
      dirQ <= '1;
    end else begin
      if (strobe.wrLat) latQ <= wrData[PW-1:0];
      if (strobe.wrDir) dirQ <= wrData[PW-1:0];
    end
  end

  for (genvar s = 0; s < SYNC_STAGES; s++) begin : gSync
    always_ff @(posedge clk) begin
      if (!rstN)       syncQ[s] <= '0;
      else if (s == 0) syncQ[s] <= pinIn;
      else             syncQ[s] <= syncQ[(s == 0) ? 0 : s-1];
    end
  end

  always_comb begin
    claimMask = (analogSel & ANALOG_CAP) | (cmpEn ? CMP_IN_MASK : '0);
    pinView   = syncQ[SYNC_STAGES-1] & ~claimMask;
  end

  for (genvar i = 0; i < PW; i++) begin : gPad
    if (i == CMP_OUT_IDX) begin : gCmp
      assign pinOut[i] = cmpEn ? cmpOut : latQ[i];
    end else begin : gLat
      assign pinOut[i] = latQ[i];
    end
    assign pinOe[i] = ~dirQ[i];
  end

  always_comb begin
    unique case (strobe.rdSel)
      SEL_PIN: rdNext = pinView;
      SEL_LAT: rdNext = latQ;
      SEL_DIR: rdNext = dirQ;
      default: rdNext = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) rdData <= '0;
    else       rdData <= {{PAD_W{1'b0}}, rdNext};
  end
endmodule

// File: rtl/gpio5_port.sv
module gpio5_port
  import gpio5_pkg::*;
#(
  parameter int                SYNC_STAGES = 2,
  parameter logic [PORT_W-1:0] ANALOG_CAP  = 5'h0F,
  parameter logic [PORT_W-1:0] CMP_IN_MASK = 5'h09,
  parameter int                CMP_OUT_IDX = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [BUS_W-1:0]  busWrData,
  output logic [BUS_W-1:0]  busRdData,
  input  logic [PORT_W-1:0] analogSel,
  input  logic              cmpEn,
  input  logic              cmpOut,
  input  logic [PORT_W-1:0] pinIn,
  output logic [PORT_W-1:0] pinOut,
  output logic [PORT_W-1:0] pinOe
);
  portStrobe_t strobe;

  gpio5_ctrl uCtrl (
    .busAddr(busAddr),
    .busWrEn(busWrEn),
    .strobe (strobe)
  );

  gpio5_datapath #(
    .PW(PORT_W), .BW(BUS_W), .SYNC_STAGES(SYNC_STAGES),
    .ANALOG_CAP(ANALOG_CAP), .CMP_IN_MASK(CMP_IN_MASK), .CMP_OUT_IDX(CMP_OUT_IDX)
  ) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .wrData(busWrData), .rdData(busRdData),
    .analogSel(analogSel), .cmpEn(cmpEn), .cmpOut(cmpOut),
    .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );
endmodule

// File: rtl/gpio5_port_chk.sv
module gpio5_port_chk
  import gpio5_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [BUS_W-1:0]  busWrData,
  input logic [BUS_W-1:0]  busRdData,
  input logic [PORT_W-1:0] analogSel,
  input logic              cmpEn,
  input logic              cmpOut,
  input logic [PORT_W-1:0] pinOut,
  input logic [PORT_W-1:0] pinOe
);
  assert_dir_oe_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == 2'd2) |=> pinOe == ~$past(busWrData[PORT_W-1:0]));

  assert_latch_load_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr < 2'd2) |=> pinOut[3:0] == $past(busWrData[3:0]));

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    (!busWrEn || busAddr == 2'd3) |=> ($stable(pinOut[3:0]) && $stable(pinOe)));

  assert_analog_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd0) |=> (busRdData[3:0] & $past(analogSel[3:0])) == 4'd0);

  assert_cmp_in_zero_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr == 2'd0 && cmpEn) |=> (busRdData[0] == 1'b0 && busRdData[3] == 1'b0));

  assert_cmp_drive_R8: assert property (@(posedge clk) disable iff (!rstN)
    cmpEn |-> pinOut[4] == cmpOut);

  always @(negedge clk)
    if (rstN) assert_upper_zero_R9: assert (busRdData[7:5] == 3'd0);
endmodule

bind gpio5_port gpio5_port_chk uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .busRdData(busRdData), .analogSel(analogSel),
  .cmpEn(cmpEn), .cmpOut(cmpOut), .pinOut(pinOut), .pinOe(pinOe)
);

// File: tb/sim_gpio5_port.sv
`timescale 1ns/1ps
module sim_gpio5_port;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = 2'd3;
  logic       busWrEn = 1'b0;
  logic [7:0] busWrData = '0;
  logic [7:0] busRdData;
  logic [4:0] analogSel = 5'h1F;
  logic       cmpEn = 1'b0;
  logic       cmpOut = 1'b0;
  logic [4:0] pinIn = 5'h1F;
  logic [4:0] pinOut, pinOe;
  int nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  gpio5_port u0 (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData), .analogSel(analogSel),
    .cmpEn(cmpEn), .cmpOut(cmpOut), .pinIn(pinIn), .pinOut(pinOut), .pinOe(pinOe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0; busAddr = 2'd3;
  endtask

  task automatic readReg(input logic [1:0] a, output logic [7:0] d);
    busAddr = a;
    @(negedge clk);
    d = busRdData;
    busAddr = 2'd3;
  endtask

  task automatic testReset();
    logic [7:0] v;
    check("R1 oe", {3'd0, pinOe}, 8'h00);
    readReg(2'd2, v); check("R1 dir", v, 8'h1F);
    readReg(2'd1, v); check("R1 latch", v, 8'h00);
    readReg(2'd0, v); check("R5 reset analog pin read", v, 8'h10);
  endtask

  task automatic testDirection();
    analogSel = 5'h00;
    writeReg(2'd1, 8'h15);
    writeReg(2'd2, 8'h0A);
    check("R2 oe", {3'd0, pinOe}, 8'h15);
    check("R2 out", {3'd0, pinOut}, 8'h15);
    writeReg(2'd2, 8'h1F);
    check("R2 released", {3'd0, pinOe}, 8'h00);
  endtask

  task automatic testSync();
    logic [7:0] v;
    pinIn = 5'h00;
    repeat (4) @(negedge clk);
    pinIn = 5'h16;
    readReg(2'd0, v); check("R3 edge1 old", v, 8'h00);
    readReg(2'd0, v); check("R3 edge2 old", v, 8'h00);
    readReg(2'd0, v); check("R3 edge3 new", v, 8'h16);
  endtask

  task automatic testLatch();
    logic [7:0] v;
    writeReg(2'd0, 8'h1B);
    pinIn = 5'h04;
    repeat (3) @(negedge clk);
    readReg(2'd1, v); check("R4 latch vs pins", v, 8'h1B);
    readReg(2'd0, v); check("R4 pin view", v, 8'h04);
    check("R4 out via port write", {3'd0, pinOut}, 8'h1B);
  endtask

  task automatic testAnalog();
    logic [7:0] v;
    pinIn = 5'h1F;
    analogSel = 5'h1A;
    writeReg(2'd2, 8'h17);
    repeat (3) @(negedge clk);
    readReg(2'd0, v); check("R5 analog reads zero", v, 8'h15);
    check("R6 analog oe", {3'd0, pinOe}, 8'h08);
    analogSel = 5'h00;
  endtask

  task automatic testCmp();
    logic [7:0] v;
    writeReg(2'd1, 8'h00);
    pinIn = 5'h1F;
    cmpEn = 1'b1; cmpOut = 1'b1;
    repeat (3) @(negedge clk);
    readReg(2'd0, v); check("R7 cmp inputs zero", v, 8'h16);
    check("R8 cmp drive 1", {7'd0, pinOut[4]}, 8'h01);
    cmpOut = 1'b0; #1;
    check("R8 cmp drive 0", {7'd0, pinOut[4]}, 8'h00);
    writeReg(2'd1, 8'h10);
    cmpEn = 1'b0; #1;
    check("R8 latch drive", {7'd0, pinOut[4]}, 8'h01);
  endtask

  task automatic testUnused();
    logic [7:0] v;
    writeReg(2'd1, 8'hE5);
    readReg(2'd1, v); check("R9 upper zero", v, 8'h05);
    writeReg(2'd3, 8'h1A);
    readReg(2'd3, v); check("R9 addr3 reads zero", v, 8'h00);
    readReg(2'd1, v); check("R9 addr3 latch kept", v, 8'h05);
    readReg(2'd2, v); check("R9 addr3 dir kept", v, 8'h17);
  endtask

  task automatic testOpenDrain();
    writeReg(2'd1, 8'h00);
    writeReg(2'd2, 8'h1D);
    check("R10 drive low oe", {3'd0, pinOe}, 8'h02);
    check("R10 drive low out", {6'd0, pinOut[1], 1'b0}, 8'h00);
    writeReg(2'd2, 8'h1F);
    check("R10 release", {3'd0, pinOe}, 8'h00);
  endtask

  task automatic testSameCycle();
    logic [7:0] v;
    writeReg(2'd1, 8'h0C);
    v = busRdData;
    busAddr = 2'd1;
    @(negedge clk);
    check("R11 idle read", busRdData, 8'h0C);
    busWrData = 8'h13; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    check("R11 same-cycle old value", busRdData, 8'h0C);
    @(negedge clk);
    check("R11 new value next", busRdData, 8'h13);
    busAddr = 2'd2; busWrData = 8'h01; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
    check("R11 dir same-cycle old", busRdData, 8'h1F);
    busAddr = 2'd3;
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testDirection();
    testSync();
    testLatch();
    testAnalog();
    testCmp();
    testUnused();
    testOpenDrain();
    testSameCycle();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule